// File: doc/BRIEF.md
# Flash Erase Command Interpreter

This block is the device-side command state machine of a flash memory model, limited to erase. It watches single-cycle bus writes (address plus data) and recognises two six-write command sequences. One erases the whole chip. The other erases selected sectors. Each sequence is made of an unlock pair, an erase setup code, a second unlock pair and a final erase code.

After the final sector-erase write, an accept window opens. During the window, more sector-erase writes may add sectors to an erase mask, and each of them restarts the window. When the window expires, a modelled internal erase runs for a fixed number of clock cycles. The block then returns to array read mode and clears the mask.

The ready output reports the busy period. A status bit reports that the accept window has expired. A toggle bit flips on every status read taken while the block is busy. An asynchronous hardware reset aborts any operation at once.

States and transitions:

- `ST_READ` moves to `ST_UNL1` on the first unlock write.
- `ST_UNL1` moves to `ST_UNL2` on the second unlock write.
- `ST_UNL2` moves to `ST_SETUP` on the setup code.
- `ST_SETUP` moves to `ST_UNL3` on the first unlock write.
- `ST_UNL3` moves to `ST_UNL4` on the second unlock write.
- `ST_UNL4` has two exits:
  - the chip code moves it to `ST_ERASING`;
  - the sector code moves it to `ST_SECT_WIN`.
- In any state from `ST_UNL1` to `ST_UNL4`, a mismatching write returns the block to `ST_READ`.
- `ST_SECT_WIN` has four outcomes:
  - a sector write adds its sector and restarts the window;
  - a suspend code is absorbed;
  - any other write aborts to `ST_READ`;
  - expiry moves it to `ST_ERASING`.
- `ST_ERASING` returns to `ST_READ` after the erase duration.

Top module: `flerase_ctl`

## Requirements
- R1: While reset is low and after its release, ready=1, erase_mask=0, tmr_expired=0 and toggle_bit=0; lowering reset during an erase forces these values at once, without waiting for a clock edge.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 start a chip erase from the clock edge of the sixth write. Only the low 11 address bits are compared. From that edge, ready=0 and erase_mask is all ones.
- R3: Ending the same sequence with 0x30 at any address opens the sector accept window. The sector index is the top SECT_W bits of the address, and that bit of erase_mask is set. ready goes 0 from that edge.
- R4: The window closes WIN_CYC clock edges after the last accepted 0x30 write. A further 0x30 write accepted at any edge inside the window, including the last one, adds its sector and restarts the count.
- R5: In the window, a 0xB0 write changes nothing and does not restart the count. Any write other than 0x30 or 0xB0 returns to read mode: ready=1, erase_mask=0, and no erase follows.
- R6: A wrong address or data value in any of the six sequence writes returns to read mode with ready=1 and erase_mask=0. A correct sequence written next is then accepted.
- R7: While the erase runs, all writes are ignored. erase_mask is unchanged and the erase duration is not extended.
- R8: The erase lasts ERASE_CYC clock edges. It then returns to read mode with ready=1 and erase_mask cleared.
- R9: tmr_expired is 0 while the window is open and 1 while the erase runs.
- R10: toggle_bit inverts on each rd_en cycle while busy (in the window or erasing). It holds its value on reads in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Status read strobe |
| ready | output | 1 | 1 = ready, 0 = busy from sequence end to erase completion |
| tmr_expired | output | 1 | Sector accept window has expired (erase running) |
| toggle_bit | output | 1 | Flips on each status read while busy |
| erase_mask | output | 2**SECT_W | Sectors selected for erase |

## Verification
Embedded assertions check on every cycle that:
- the mask is empty in read mode;
- the mask is non-empty in the window;
- the mask is frozen while erasing;
- a chip code sets every sector;
- the counter never passes its limit;
- the toggle bit holds when it is not read during a busy period;
- ready returns on the cycle after the erase limit is reached.

Only the bench's scenarios can show the following, because they depend on exact cycle counts and on full write sequences:
- the window length;
- that restart happens at every possible offset;
- that the suspend code does not restart the window;
- abort on each foreign code;
- recovery after a corrupted write at each of the six positions.

// File: rtl/flerase_pkg.sv
package flerase_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_SETUP,
        ST_UNL3,
        ST_UNL4,
        ST_SECT_WIN,
        ST_ERASING
    } state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_KEY_A,
        CMD_KEY_B,
        CMD_SETUP,
        CMD_CHIP,
        CMD_SECT,
        CMD_SUSP,
        CMD_OTHER
    } cmd_t;

    localparam logic [10:0] ADR_KEY_A = 11'h555;
    localparam logic [10:0] ADR_KEY_B = 11'h2AA;
    localparam logic [7:0]  DAT_KEY_A = 8'hAA;
    localparam logic [7:0]  DAT_KEY_B = 8'h55;
    localparam logic [7:0]  DAT_SETUP = 8'h80;
    localparam logic [7:0]  DAT_CHIP  = 8'h10;
    localparam logic [7:0]  DAT_SECT  = 8'h30;
    localparam logic [7:0]  DAT_SUSP  = 8'hB0;

endpackage

// File: rtl/flerase_decode.sv
module flerase_decode
    import flerase_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              wr_en,
    input  logic [10:0]       addr_lo,
    input  logic [DATA_W-1:0] data,
    output cmd_t              cmd
);

    logic hit_a;
    logic hit_b;

    assign hit_a = (addr_lo == ADR_KEY_A);
    assign hit_b = (addr_lo == ADR_KEY_B);

    always_comb begin
        cmd = CMD_OTHER;
        if (!wr_en)
            cmd = CMD_NONE;
        else if (hit_a && data == DATA_W'(DAT_KEY_A))
            cmd = CMD_KEY_A;
        else if (hit_b && data == DATA_W'(DAT_KEY_B))
            cmd = CMD_KEY_B;
        else if (hit_a && data == DATA_W'(DAT_SETUP))
            cmd = CMD_SETUP;
        else if (hit_a && data == DATA_W'(DAT_CHIP))
            cmd = CMD_CHIP;
        else if (data == DATA_W'(DAT_SECT))
            cmd = CMD_SECT;
        else if (data == DATA_W'(DAT_SUSP))
            cmd = CMD_SUSP;
    end

endmodule

// File: rtl/flerase_timer.sv
module flerase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] last,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;

    assign hit = run && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (run && !hit)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |-> (cnt_q <= last)); // R4

endmodule

// File: rtl/flerase_sectbuf.sv
module flerase_sectbuf #(
    parameter int SECT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   set_all,
    input  logic                   set_en,
    input  logic [SECT_W-1:0]      set_idx,
    output logic [(1<<SECT_W)-1:0] mask
);

    localparam int NUM_SECT = 1 << SECT_W;

    for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask[i] <= 1'b0;
            else if (clr)
                mask[i] <= 1'b0;
            else if (set_all)
                mask[i] <= 1'b1;
            else if (set_en && set_idx == SECT_W'(i))
                mask[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/flerase_ctl.sv
module flerase_ctl
    import flerase_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int SECT_W    = 3,
    parameter int CLK_MHZ   = 100,
    parameter int WIN_US    = 50,
    parameter int ERASE_CYC = 20000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_en,
    output logic                   ready,
    output logic                   tmr_expired,
    output logic                   toggle_bit,
    output logic [(1<<SECT_W)-1:0] erase_mask
);

    localparam int NUM_SECT = 1 << SECT_W;
    localparam int WIN_CYC  = WIN_US * CLK_MHZ;
    localparam int MAX_CYC  = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    state_t             state_q, state_d;
    cmd_t               cmd;
    logic               cnt_clr, cnt_run, cnt_hit;
    logic [CNT_W-1:0]   cnt_last;
    logic               buf_clr, buf_all, buf_set;
    logic               busy;
    logic               toggle_q;
    logic [SECT_W-1:0]  sect_idx;

    assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];

    flerase_decode #(.DATA_W(DATA_W)) u_decode (
        .wr_en   (wr_en),
        .addr_lo (wr_addr[10:0]),
        .data    (wr_data),
        .cmd     (cmd)
    );

    flerase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .last  (cnt_last),
        .hit   (cnt_hit)
    );

    flerase_sectbuf #(.SECT_W(SECT_W)) u_sectbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .set_all (buf_all),
        .set_en  (buf_set),
        .set_idx (sect_idx),
        .mask    (erase_mask)
    );

    assign busy     = (state_q == ST_SECT_WIN) || (state_q == ST_ERASING);
    assign cnt_run  = busy;
    assign cnt_last = (state_q == ST_ERASING) ? CNT_W'(ERASE_CYC - 1)
                                              : CNT_W'(WIN_CYC - 1);

    // next state and datapath controls
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        buf_clr = 1'b0;
        buf_all = 1'b0;
        buf_set = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (cmd == CMD_KEY_A) state_d = ST_UNL1;
            end
            ST_UNL1: begin
                if (cmd == CMD_KEY_B)      state_d = ST_UNL2;
                else if (cmd != CMD_NONE)  state_d = ST_READ;
            end
            ST_UNL2: begin
                if (cmd == CMD_SETUP)      state_d = ST_SETUP;
                else if (cmd != CMD_NONE)  state_d = ST_READ;
            end
            ST_SETUP: begin
                if (cmd == CMD_KEY_A)      state_d = ST_UNL3;
                else if (cmd != CMD_NONE)  state_d = ST_READ;
            end
            ST_UNL3: begin
                if (cmd == CMD_KEY_B)      state_d = ST_UNL4;
                else if (cmd != CMD_NONE)  state_d = ST_READ;
            end
            ST_UNL4: begin
                if (cmd == CMD_CHIP) begin
                    state_d = ST_ERASING;
                    buf_all = 1'b1;
                    cnt_clr = 1'b1;
                end else if (cmd == CMD_SECT) begin
                    state_d = ST_SECT_WIN;
                    buf_set = 1'b1;
                    cnt_clr = 1'b1;
                end else if (cmd != CMD_NONE) begin
                    state_d = ST_READ;
                end
            end
            ST_SECT_WIN: begin
                if (cmd == CMD_SECT) begin
                    buf_set = 1'b1;
                    cnt_clr = 1'b1;
                end else if (cmd == CMD_NONE || cmd == CMD_SUSP) begin
                    if (cnt_hit) begin
                        state_d = ST_ERASING;
                        cnt_clr = 1'b1;
                    end
                end else begin
                    state_d = ST_READ;
                    buf_clr = 1'b1;
                end
            end
            ST_ERASING: begin
                if (cnt_hit) begin
                    state_d = ST_READ;
                    buf_clr = 1'b1;
                end
            end
            default: begin
                state_d = ST_READ;
                buf_clr = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    // status toggle register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             toggle_q <= 1'b0;
        else if (rd_en && busy) toggle_q <= ~toggle_q;
    end

    // outputs
    always_comb begin
        ready       = !busy;
        tmr_expired = (state_q == ST_ERASING);
        toggle_bit  = toggle_q;
    end

    AST_READ_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> (erase_mask == '0)); // R8

    AST_WIN_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECT_WIN) |-> (erase_mask != '0)); // R3

    AST_ERASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASING && $past(state_q) == ST_ERASING) |-> $stable(erase_mask)); // R7

    AST_CHIP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNL4 && cmd == CMD_CHIP) |=> (erase_mask == {NUM_SECT{1'b1}})); // R2

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASING && cnt_hit) |=> ready); // R8

    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && busy) |=> $stable(toggle_bit)); // R10

endmodule

// File: tb/flerase_ctl_test.sv
module flerase_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 8;
    localparam int SECT_W     = 3;
    localparam int NSECT      = 1 << SECT_W;
    localparam int WIN        = 50;   // WIN_US=50 at CLK_MHZ=1
    localparam int ERASE      = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              ready, tmr_expired, toggle_bit;
    logic [NSECT-1:0]  erase_mask;

    int n_chk = 0;
    int n_bad = 0;

    flerase_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
        .CLK_MHZ(1), .WIN_US(50), .ERASE_CYC(ERASE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .ready(ready),
        .tmr_expired(tmr_expired), .toggle_bit(toggle_bit),
        .erase_mask(erase_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [ADDR_W-1:0] sa(input int s);
        return {SECT_W'(s), 9'h0A5};
    endfunction

    // six-write sequence; bad = index of corrupted write (6 = none)
    task automatic seq6(input bit chip, input int sect, input int bad);
        logic [ADDR_W-1:0] a [6];
        logic [7:0]        d [6];
        a[0] = 12'h555; d[0] = 8'hAA;
        a[1] = 12'h2AA; d[1] = 8'h55;
        a[2] = 12'h555; d[2] = 8'h80;
        a[3] = 12'h555; d[3] = 8'hAA;
        a[4] = 12'h2AA; d[4] = 8'h55;
        if (chip) begin a[5] = 12'h555; d[5] = 8'h10; end
        else      begin a[5] = sa(sect); d[5] = 8'h30; end
        for (int i = 0; i < 6; i++)
            wr(a[i], (i == bad) ? (d[i] ^ 8'h01) : d[i]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int exp_tog;
        idle(2);
        chk("R1 ready in reset", ready, 1);
        chk("R1 mask in reset", erase_mask, 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 ready after reset", ready, 1);
        chk("R1 tmr_expired after reset", tmr_expired, 0);
        chk("R1 toggle after reset", toggle_bit, 0);

        // R2 chip erase and R8 completion
        seq6(1'b1, 0, 6);
        chk("R2 chip busy", ready, 0);
        chk("R2 chip mask", erase_mask, 8'hFF);
        chk("R9 chip erasing flag", tmr_expired, 1);
        idle(ERASE - 1);
        chk("R8 chip still busy", ready, 0);
        idle(1);
        chk("R8 chip done ready", ready, 1);
        chk("R8 chip mask cleared", erase_mask, 0);

        // R3/R4/R9 every sector alone
        for (int s = 0; s < NSECT; s++) begin
            seq6(1'b0, s, 6);
            chk("R3 sector mask", erase_mask, 1 << s);
            chk("R3 sector busy", ready, 0);
            chk("R9 window open flag", tmr_expired, 0);
            idle(WIN - 1);
            chk("R4 window still open", tmr_expired, 0);
            idle(1);
            chk("R9 window expired flag", tmr_expired, 1);
            idle(ERASE - 1);
            chk("R8 sector still busy", ready, 0);
            idle(1);
            chk("R8 sector done", ready, 1);
            chk("R8 sector mask cleared", erase_mask, 0);
        end

        // R4 restart at every offset inside the window
        for (int g = 0; g < WIN; g++) begin
            seq6(1'b0, 0, 6);
            idle(g);
            wr(sa((g % 7) + 1), 8'h30);
            chk("R4 added sector", erase_mask, 1 | (1 << ((g % 7) + 1)));
            idle(WIN - 1);
            chk("R4 restarted window open", tmr_expired, 0);
            idle(1);
            chk("R4 restarted window closed", tmr_expired, 1);
            idle(ERASE);
            chk("R8 done after restart", ready, 1);
        end

        // R4 all sectors collected
        seq6(1'b0, 0, 6);
        for (int s = 1; s < NSECT; s++) begin
            idle(3);
            wr(sa(s), 8'h30);
        end
        chk("R4 all sectors", erase_mask, 8'hFF);
        idle(WIN + ERASE);
        chk("R8 all sectors done", ready, 1);

        // R5 suspend code absorbed without restart
        seq6(1'b0, 2, 6);
        idle(10);
        wr(12'h000, 8'hB0);
        idle(WIN - 12);
        chk("R5 suspend window open", tmr_expired, 0);
        chk("R5 suspend mask", erase_mask, 1 << 2);
        chk("R5 suspend busy", ready, 0);
        idle(1);
        chk("R5 suspend no restart", tmr_expired, 1);
        idle(ERASE);

        // R5 foreign codes abort
        for (int k = 0; k < 5; k++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0]        d;
            case (k)
                0: begin a = 12'h555; d = 8'hAA; end
                1: begin a = 12'h2AA; d = 8'h55; end
                2: begin a = 12'h555; d = 8'h80; end
                3: begin a = 12'h555; d = 8'h10; end
                default: begin a = 12'h000; d = 8'hF0; end
            endcase
            seq6(1'b0, 5, 6);
            idle(4);
            wr(a, d);
            chk("R5 abort ready", ready, 1);
            chk("R5 abort mask", erase_mask, 0);
            idle(WIN + 5);
            chk("R5 no erase after abort", ready, 1);
        end

        // R6 corrupted write at each position
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 6; p++) begin
                seq6(c == 0, 4, p);
                chk("R6 corrupt ready", ready, 1);
                chk("R6 corrupt mask", erase_mask, 0);
                seq6(1'b1, 0, 6);
                chk("R6 recovery accepted", erase_mask, 8'hFF);
                idle(ERASE);
                chk("R6 recovery done", ready, 1);
            end
        end

        // R7 writes ignored while erasing
        seq6(1'b0, 1, 6);
        idle(WIN);
        chk("R7 erasing started", tmr_expired, 1);
        wr(sa(6), 8'h30);
        wr(12'h555, 8'hAA);
        wr(12'h000, 8'hF0);
        chk("R7 mask unchanged", erase_mask, 1 << 1);
        idle(ERASE - 4);
        chk("R7 duration unchanged busy", ready, 0);
        idle(1);
        chk("R7 duration unchanged done", ready, 1);

        // R10 toggle bit
        exp_tog = 0;
        rd();
        chk("R10 no toggle when idle", toggle_bit, exp_tog);
        seq6(1'b0, 3, 6);
        for (int i = 0; i < 3; i++) begin
            rd();
            exp_tog ^= 1;
            chk("R10 toggle in window", toggle_bit, exp_tog);
        end
        idle(WIN);
        for (int i = 0; i < 2; i++) begin
            rd();
            exp_tog ^= 1;
            chk("R10 toggle while erasing", toggle_bit, exp_tog);
        end
        idle(ERASE);
        rd();
        chk("R10 no toggle after done", toggle_bit, exp_tog);

        // R1 hardware reset aborts erase immediately
        seq6(1'b1, 0, 6);
        idle(5);
        rst_n = 1'b0;
        #1;
        chk("R1 reset abort ready", ready, 1);
        chk("R1 reset abort mask", erase_mask, 0);
        chk("R1 reset abort flag", tmr_expired, 0);
        chk("R1 reset abort toggle", toggle_bit, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        seq6(1'b1, 0, 6);
        chk("R2 chip after reset", erase_mask, 8'hFF);
        idle(ERASE);
        chk("R8 done after reset", ready, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule